// File: doc/BRIEF.md
# Edge/Level Interrupt Pending Controller

This block gathers interrupt requests from eight active-low external pins and eight internal level-request lines into one 32-bit pending register. A simple synchronous register bus reads the pending register, a per-bit mask register and a per-pin sensitivity register, and writes all three. The masked pending bits are combined into one registered interrupt-request output for the processor.

Each external pin passes through a two-flop synchronizer and then drives a small per-pin state machine. The machine has two states. `CELL_IDLE` means nothing is pending and `CELL_HELD` means the bit is pending. In level mode (sensitivity 0) it follows the pin. The transition `LVL_ASSERT` goes from IDLE to HELD while the pin is low, and `LVL_RELEASE` goes from HELD to IDLE while the pin is high. In edge mode (sensitivity 1) the transition `EDGE_CAPTURE` goes from IDLE to HELD on a falling edge, and `SW_CLEAR` goes from HELD to IDLE on a write-one-to-clear that does not coincide with a new falling edge. Otherwise the state holds. The internal lines are registered straight into their pending bits and ignore bus writes.

Top module: `irq_pending_ctrl`

## Requirements
- R1: Pending bits use big-endian numbering, with position p at vector index 31-p. External pin n sits at position 2n (index 31-2n) and internal line n at position 2n+1 (index 30-2n). Position 10 (pin 5) and positions 16 to 31 are reserved and always read 0. Pin 5 never sets a pending bit.
- R2: Asynchronous hard reset (`rst_n` low) and synchronous soft reset (`soft_rst` high) both clear the pending, mask and sensitivity registers and drive `irq_out` to 0.
- R3: Each internal pending bit equals `int_lvl[n]` as sampled at the previous clock edge. Bus writes to the pending register never change it.
- R4: In level mode the external pending bit is 1 exactly when the pin is low, with a latency of three clock edges from a pin change (two synchronizer stages plus the pending register).
- R5: In edge mode, a falling edge on a pin sets its pending bit three edges after the pin falls. The bit then stays set whatever the pin does afterwards.
- R6: A bus write to address 0 clears every edge-mode pending bit whose write-data bit is 1, effective at the next edge. Write-data bits of 0 have no effect, and level-mode bits are not affected by writes.
- R7: While an edge-mode bit is set and not cleared, further falling edges leave it at 1, and a single clear removes it.
- R8: If a clear of a bit and a new falling edge on that pin land on the same edge, the bit stays set.
- R9: `irq_out` is registered: it equals the OR over all bits of (pending AND mask) from the previous cycle.
- R10: Address 1 is the mask register. Only the positions that hold pending bits are writable, and the others read 0. Address 2 is the sensitivity register, with pin n at position n (index 31-n) and the rest reading 0. Address 3 reads 0. Reads are combinational from `bus_addr`.
- R11: Switching a pin from level to edge mode while its bit is set keeps the bit set until it is cleared by a write, even after the pin rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hard reset, active low |
| soft_rst | input | 1 | Synchronous soft reset, active high |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select: 0 pending, 1 mask, 2 sensitivity |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the selected register |
| ext_req_n | input | 8 | External request pins, active low, asynchronous |
| int_lvl | input | 8 | Internal level requests, active high, synchronous |
| irq_out | output | 1 | Combined masked interrupt request |

## Verification
A per-pin state machine stuck in the wrong state shows up on `bus_rdata` at address 0 three edges after the pin stimulus that should have moved it. That same error reaches `irq_out` one edge later if the bit is unmasked. Lost or false edges, clears that miss, and a collision that resolves the wrong way all leave a sticky bit with the wrong value, and that wrong value persists until the next clear. A mask or sensitivity bit stored at the wrong position appears as an immediate readback mismatch. It also appears as a wrong mode on the next pin toggle.

// File: rtl/irqp_pkg.sv
package irqp_pkg;

    // Register select codes on the bus
    localparam int unsigned ADDR_PEND  = 0;
    localparam int unsigned ADDR_MASK  = 1;
    localparam int unsigned ADDR_SENSE = 2;

    // Per-pin pending state
    typedef enum logic {
        CELL_IDLE = 1'b0,
        CELL_HELD = 1'b1
    } cell_st_e;

endpackage

// File: rtl/irqp_sync.sv
module irqp_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         soft_rst,
    input  logic [W-1:0] pin_n,
    output logic [W-1:0] cur_n,
    output logic [W-1:0] prev_n
);
    // STAGES synchronizer flops plus one history flop for edge detection
    localparam int DEPTH = STAGES + 1;

    logic [W-1:0] chain [DEPTH];

    for (genvar s = 0; s < DEPTH; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain[s] <= '1;
            end else if (soft_rst) begin
                chain[s] <= '1;
            end else if (s == 0) begin
                chain[s] <= pin_n;
            end else begin
                chain[s] <= chain[(s == 0) ? 0 : s-1];
            end
        end
    end

    assign cur_n  = chain[STAGES-1];
    assign prev_n = chain[STAGES];

endmodule

// File: rtl/irqp_pin_cell.sv
module irqp_pin_cell
    import irqp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic edge_mode,
    input  logic cur_n,
    input  logic prev_n,
    input  logic clr,
    output logic pend
);
    cell_st_e state_q, state_d;
    logic     fall;

    assign fall = prev_n & ~cur_n;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CELL_IDLE;
        end else if (soft_rst) begin
            state_q <= CELL_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CELL_IDLE: begin
                if (edge_mode) begin
                    if (fall) state_d = CELL_HELD;        // EDGE_CAPTURE
                end else begin
                    if (!cur_n) state_d = CELL_HELD;      // LVL_ASSERT
                end
            end
            CELL_HELD: begin
                if (edge_mode) begin
                    if (clr && !fall) state_d = CELL_IDLE; // SW_CLEAR
                end else begin
                    if (cur_n) state_d = CELL_IDLE;       // LVL_RELEASE
                end
            end
        endcase
    end

    // Outputs
    always_comb begin
        pend = (state_q == CELL_HELD);
    end

    // R5: an edge-mode bit that is set and not cleared stays set
    a_r5_edge_sticky: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
        (edge_mode && pend && !clr) |=> pend);

    // R6: a clear without a coinciding fall drops an edge-mode bit
    a_r6_w1c_drops: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
        (edge_mode && pend && clr && !fall) |=> !pend);

    // R8: a detected fall always leaves the bit set, clear or not
    a_r8_fall_wins: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
        (edge_mode && fall) |=> pend);

    // R4: level mode follows the synchronized pin one edge later
    a_r4_level_track: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
        (!edge_mode) |=> (pend == $past(!cur_n)));

endmodule

// File: rtl/irq_pending_ctrl.sv
module irq_pending_ctrl
    import irqp_pkg::*;
#(
    parameter int                   NUM_SRC  = 8,
    parameter int                   REG_W    = 32,
    parameter int                   ADDR_W   = 2,
    parameter int                   SYNC_STG = 2,
    parameter logic [NUM_SRC-1:0]   RSVD_EXT = 8'h20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic [NUM_SRC-1:0] ext_req_n,
    input  logic [NUM_SRC-1:0] int_lvl,
    output logic              irq_out
);
    // Bit positions of pending sources, big-endian numbering
    function automatic logic [REG_W-1:0] valid_bits();
        logic [REG_W-1:0] v;
        v = '0;
        for (int n = 0; n < NUM_SRC; n++) begin
            if (!RSVD_EXT[n]) v[REG_W-1-2*n] = 1'b1;
            v[REG_W-2-2*n] = 1'b1;
        end
        return v;
    endfunction

    localparam logic [REG_W-1:0] VALID_BITS = valid_bits();

    logic                sel_pend, sel_mask, sel_sense;
    logic [NUM_SRC-1:0]  cur_n, prev_n;
    logic [NUM_SRC-1:0]  ext_pend, clr_vec;
    logic [NUM_SRC-1:0]  int_q;
    logic [NUM_SRC-1:0]  sense_q;
    logic [REG_W-1:0]    mask_q;
    logic [REG_W-1:0]    pend_vec;
    logic [REG_W-1:0]    sense_vec;
    logic                irq_q;

    // Register select
    assign sel_pend  = (bus_addr == ADDR_W'(ADDR_PEND));
    assign sel_mask  = (bus_addr == ADDR_W'(ADDR_MASK));
    assign sel_sense = (bus_addr == ADDR_W'(ADDR_SENSE));

    // Pin synchronizer with edge history
    irqp_sync #(.W(NUM_SRC), .STAGES(SYNC_STG)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .soft_rst(soft_rst),
        .pin_n   (ext_req_n),
        .cur_n   (cur_n),
        .prev_n  (prev_n)
    );

    // One state machine per external pin
    for (genvar n = 0; n < NUM_SRC; n++) begin : g_pin
        assign clr_vec[n] = bus_we & sel_pend & bus_wdata[REG_W-1-2*n];

        irqp_pin_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .soft_rst (soft_rst),
            .edge_mode(sense_q[n]),
            .cur_n    (cur_n[n]),
            .prev_n   (prev_n[n]),
            .clr      (clr_vec[n]),
            .pend     (ext_pend[n])
        );
    end

    // Internal level requests, mask and sensitivity registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            int_q   <= '0;
            mask_q  <= '0;
            sense_q <= '0;
        end else if (soft_rst) begin
            int_q   <= '0;
            mask_q  <= '0;
            sense_q <= '0;
        end else begin
            int_q <= int_lvl;
            if (bus_we && sel_mask) mask_q <= bus_wdata & VALID_BITS;
            if (bus_we && sel_sense) begin
                for (int n = 0; n < NUM_SRC; n++) sense_q[n] <= bus_wdata[REG_W-1-n];
            end
        end
    end

    // Pending and sensitivity views in register layout
    always_comb begin
        pend_vec  = '0;
        sense_vec = '0;
        for (int n = 0; n < NUM_SRC; n++) begin
            pend_vec[REG_W-1-2*n] = ext_pend[n] & ~RSVD_EXT[n];
            pend_vec[REG_W-2-2*n] = int_q[n];
            sense_vec[REG_W-1-n]  = sense_q[n];
        end
    end

    // Combined request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else if (soft_rst) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= |(pend_vec & mask_q);
        end
    end

    assign irq_out = irq_q;

    // Read mux
    always_comb begin
        bus_rdata = '0;
        if (sel_pend)       bus_rdata = pend_vec;
        else if (sel_mask)  bus_rdata = mask_q;
        else if (sel_sense) bus_rdata = sense_vec;
    end

    // R9: output reflects last cycle's masked pending bits
    a_r9_irq_registered: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
        1'b1 |=> (irq_out == $past(|(pend_vec & mask_q))));

    // R3: internal bits follow their sources even across pending writes
    a_r3_int_ignores_write: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
        (bus_we && sel_pend) |=> (int_q == $past(int_lvl)));

    // R1: reserved positions never read as set
    a_r1_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
        sel_pend |-> ((bus_rdata & ~VALID_BITS) == '0));

    // R2: soft reset empties the pending register
    a_r2_soft_clear: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (pend_vec == '0 && !irq_out));

endmodule

// File: tb/irq_pending_ctrl_bench.sv
module irq_pending_ctrl_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  ext_req_n = 8'hFF;
    logic [7:0]  int_lvl = 8'h00;
    logic        irq_out;

    int    n_checks = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    string phase = "R2";

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_pending_ctrl u_irq_pending_ctrl (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .ext_req_n(ext_req_n), .int_lvl(int_lvl),
        .irq_out(irq_out)
    );

    // Behavioural reference model
    logic [31:0] m_pend = '0, m_mask = '0;
    logic [7:0]  m_sense = '0;
    logic        m_irq = 1'b0;
    logic [7:0]  h1 = 8'hFF, h2 = 8'hFF, h3 = 8'hFF;
    localparam logic [31:0] VALID = 32'hFFDF_0000;

    function automatic logic [31:0] sense_view(logic [7:0] s);
        logic [31:0] v = '0;
        for (int n = 0; n < 8; n++) v[31-n] = s[n];
        return v;
    endfunction

    always @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            m_pend = '0; m_mask = '0; m_sense = '0; m_irq = 1'b0;
            h1 = 8'hFF; h2 = 8'hFF; h3 = 8'hFF;
        end else begin
            logic [31:0] np;
            np = '0;
            for (int n = 0; n < 8; n++) begin
                logic fell, wclr, old;
                np[30-2*n] = int_lvl[n];
                fell = h3[n] && !h2[n];
                wclr = bus_we && bus_addr == 2'd0 && bus_wdata[31-2*n];
                old  = m_pend[31-2*n];
                if (n == 5)           np[31-2*n] = 1'b0;
                else if (!m_sense[n]) np[31-2*n] = !h2[n];
                else                  np[31-2*n] = fell || (old && !wclr);
            end
            m_irq = |(m_pend & m_mask);
            m_pend = np;
            if (bus_we && bus_addr == 2'd1) m_mask = bus_wdata & VALID;
            if (bus_we && bus_addr == 2'd2)
                for (int n = 0; n < 8; n++) m_sense[n] = bus_wdata[31-n];
            h3 = h2; h2 = h1; h1 = ext_req_n;
        end
    end

    // Per-clock comparison against the model
    always @(negedge clk) begin
        if (!done) begin
            logic [31:0] er;
            case (bus_addr)
                2'd0: er = m_pend;
                2'd1: er = m_mask;
                2'd2: er = sense_view(m_sense);
                default: er = '0;
            endcase
            n_checks++;
            if (irq_out !== m_irq) begin
                n_fail++;
                $display("FAIL %s/R9 irq_out act=%0b exp=%0b t=%0t", phase, irq_out, m_irq, $time);
            end
            n_checks++;
            if (bus_rdata !== er) begin
                n_fail++;
                $display("FAIL %s rdata[%0d] act=%h exp=%h t=%0t", phase, bus_addr, bus_rdata, er, $time);
            end
        end
    end

    task automatic cyc(int k);
        repeat (k) @(negedge clk);
        #1;
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        cyc(1);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(string req, logic [1:0] a, logic [31:0] exp);
        bus_addr = a;
        #1;
        n_checks++;
        if (bus_rdata !== exp) begin
            n_fail++;
            $display("FAIL %s read[%0d] act=%h exp=%h", req, a, bus_rdata, exp);
        end
    endtask

    task automatic chk_irq(string req, logic exp);
        n_checks++;
        if (irq_out !== exp) begin
            n_fail++;
            $display("FAIL %s irq_out act=%0b exp=%0b", req, irq_out, exp);
        end
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(2);
        phase = "R2";
        rd("R2", 2'd0, 32'h0); rd("R2", 2'd1, 32'h0); rd("R2", 2'd2, 32'h0);
        chk_irq("R2", 1'b0);

        phase = "R10";
        wr(2'd1, 32'hFFFF_FFFF); rd("R10", 2'd1, 32'hFFDF_0000);
        wr(2'd2, 32'hFFFF_FFFF); rd("R10", 2'd2, 32'hFF00_0000);
        rd("R10", 2'd3, 32'h0);
        wr(2'd1, 32'h0); wr(2'd2, 32'h0);

        phase = "R3";
        bus_addr = 2'd0;
        int_lvl = 8'h81; cyc(2);
        rd("R3", 2'd0, 32'h4001_0000);
        wr(2'd0, 32'hFFFF_FFFF); cyc(1);
        rd("R3", 2'd0, 32'h4001_0000);
        int_lvl = 8'h00; cyc(2);
        rd("R3", 2'd0, 32'h0);

        phase = "R4";
        ext_req_n = 8'hFE; cyc(2);
        rd("R4", 2'd0, 32'h0);
        cyc(1);
        rd("R4", 2'd0, 32'h8000_0000);
        wr(2'd0, 32'h8000_0000); cyc(1);
        rd("R4", 2'd0, 32'h8000_0000);
        ext_req_n = 8'hFF; cyc(4);
        rd("R4", 2'd0, 32'h0);

        phase = "R5";
        wr(2'd2, 32'hFF00_0000);
        bus_addr = 2'd0;
        ext_req_n = 8'hFE; cyc(1); ext_req_n = 8'hFF; cyc(1);
        rd("R5", 2'd0, 32'h0);
        cyc(1);
        rd("R5", 2'd0, 32'h8000_0000);
        cyc(5);
        rd("R5", 2'd0, 32'h8000_0000);

        phase = "R6";
        wr(2'd0, 32'h7FFF_FFFF); cyc(1);
        rd("R6", 2'd0, 32'h8000_0000);

        phase = "R7";
        for (int i = 0; i < 3; i++) begin
            ext_req_n = 8'hFE; cyc(2); ext_req_n = 8'hFF; cyc(2);
        end
        cyc(3);
        rd("R7", 2'd0, 32'h8000_0000);
        wr(2'd0, 32'h8000_0000);
        rd("R6", 2'd0, 32'h0);

        phase = "R8";
        ext_req_n = 8'hFE; cyc(1); ext_req_n = 8'hFF; cyc(6);
        rd("R8", 2'd0, 32'h8000_0000);
        ext_req_n = 8'hFE; cyc(2);
        wr(2'd0, 32'h8000_0000);
        bus_addr = 2'd0; cyc(1);
        rd("R8", 2'd0, 32'h8000_0000);
        ext_req_n = 8'hFF; cyc(3);

        phase = "R9";
        wr(2'd1, 32'h8000_0000);
        bus_addr = 2'd0;
        cyc(1);
        chk_irq("R9", 1'b1);
        wr(2'd1, 32'h4000_0000);
        cyc(1);
        chk_irq("R9", 1'b0);
        int_lvl = 8'h01; cyc(1);
        chk_irq("R9", 1'b0);
        cyc(1);
        chk_irq("R9", 1'b1);
        int_lvl = 8'h00;
        wr(2'd0, 32'h8000_0000); wr(2'd1, 32'h0);
        cyc(3);

        phase = "R11";
        wr(2'd2, 32'h0);
        bus_addr = 2'd0;
        ext_req_n = 8'hFD; cyc(4);
        rd("R11", 2'd0, 32'h2000_0000);
        wr(2'd2, 32'h4000_0000);
        ext_req_n = 8'hFF; cyc(5);
        rd("R11", 2'd0, 32'h2000_0000);
        wr(2'd0, 32'h2000_0000); cyc(1);
        rd("R11", 2'd0, 32'h0);

        phase = "R1";
        ext_req_n = 8'hDF; cyc(5);
        rd("R1", 2'd0, 32'h0);
        wr(2'd2, 32'h0400_0000);
        ext_req_n = 8'hFF; cyc(2); ext_req_n = 8'hDF; cyc(5);
        rd("R1", 2'd0, 32'h0);
        int_lvl = 8'h20; cyc(2);
        rd("R1", 2'd0, 32'h0010_0000);
        ext_req_n = 8'hFF;

        phase = "R2";
        wr(2'd1, 32'hFFFF_FFFF);
        ext_req_n = 8'hFE; cyc(4);
        soft_rst = 1'b1; cyc(1); soft_rst = 1'b0;
        int_lvl = 8'h00; ext_req_n = 8'hFF;
        rd("R2", 2'd1, 32'h0); rd("R2", 2'd2, 32'h0);
        chk_irq("R2", 1'b0);
        cyc(3);
        rd("R2", 2'd0, 32'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog act=timeout exp=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule